// File: doc/BRIEF.md
# Sixteen-bit timer with two compare channels and forced compare

This block is a 16-bit up-counter, advanced by a one-cycle timer tick input, with two compare channels (A and B). Each channel holds a 16-bit compare value. When the counter equals that value on an unblocked tick, the channel sets its match flag and applies its 2-bit output action to its waveform pin. The counter either runs freely and wraps with an overflow flag, or, in clear-on-compare mode, reloads zero after matching channel A.

A CPU reaches the block through eight byte-wide registers. Sixteen-bit values cross the bus through one shared high-byte latch, so both halves of a value take effect together. The control register carries two write-only strobes that force a compare action onto a waveform pin. A forced action sets no flag and does not move the counter.

The counter control is a two-state machine. `CS_RUN` is normal counting and comparing. `CS_HOLD` is entered on any CPU write to the counter. The transitions are: RUN to HOLD on a counter write; HOLD to HOLD on another counter write; HOLD to RUN on the next tick, which advances the counter but compares nothing; RUN to RUN otherwise.

Top module: `tmr16_cmp_unit`

## Requirements
- R1: After reset the counter, both compare values, the control register, all flags and both waveform pins are 0, and every register reads 0.
- R2: Writing a high-byte address (3 counter, 5 compare A, 7 compare B) only loads the shared latch. Writing the matching low byte (2, 4, 6) commits {latch, data}. Because the latch is shared, a high byte written at one address is committed by a low-byte write at another.
- R3: Reading the counter low byte (address 2) copies the counter high byte into the latch. A later read of address 3 returns that copy, even after the counter has moved.
- R4: With control bit 0 clear, each tick adds 1 to the counter. A tick at 0xFFFF gives 0 and sets the overflow flag (flag register bit 0).
- R5: A tick with the counter equal to compare A (or B), when not blocked, sets flag bit 1 (or bit 2) one edge later.
- R6: On a match the pin follows its mode field (A: control bits 5:4, B: bits 3:2): 00 holds, 01 toggles, 10 drives 0, 11 drives 1.
- R7: With control bit 0 set, a tick that matches compare A reloads the counter to 0 instead of incrementing it.
- R8: After a CPU write to the counter, the next tick advances the counter but suppresses matches on both channels: no flag, no pin action, no reload.
- R9: Writing 1 to control bit 7 (A) or bit 6 (B) applies that channel's action at once, using the mode bits in the same written byte. It sets no flag and does not clear or move the counter.
- R10: Control bits 7 and 6 always read 0. Bit 1 also reads 0.
- R11: Writing the flag register (address 1) clears each flag whose bit is 1 and leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_tick | input | 1 | One timer clock when high for a cycle |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of bus_rd |
| wave_a | output | 1 | Channel A waveform pin |
| wave_b | output | 1 | Channel B waveform pin |
| flag_ovf | output | 1 | Overflow flag |
| flag_a | output | 1 | Channel A match flag |
| flag_b | output | 1 | Channel B match flag |

## Verification
Read data is combinational: a check of a read samples bus_rdata in the same cycle that bus_rd is high. The counter, the flags and the pins change at the edge that ends a tick or write cycle, and the latch copy made by a low-byte read is valid from the next cycle on. The driver therefore holds each stimulus for exactly one cycle and queues every expectation at the falling edge of the cycle in which the result must already be present. The monitor compares 2 ns later, before the next rising edge. Tick counts are chosen so that a match lands on a known tick, which also places the suppressed tick after a counter write.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int ADDR_W  = 3;
    localparam int NUM_CH  = 2;
    localparam int FORCE_A = 7;
    localparam int FORCE_B = 6;
    localparam int CTC_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL   = 3'd0,
        RA_FLAGS  = 3'd1,
        RA_CNT_L  = 3'd2,
        RA_CNT_H  = 3'd3,
        RA_CMPA_L = 3'd4,
        RA_CMPA_H = 3'd5,
        RA_CMPB_L = 3'd6,
        RA_CMPB_H = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        OM_HOLD   = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_CLEAR  = 2'b10,
        OM_SET    = 2'b11
    } out_mode_e;

    typedef enum logic {
        CS_RUN  = 1'b0,
        CS_HOLD = 1'b1
    } cnt_state_e;
endpackage

// File: rtl/tmr16_bus_if.sv
module tmr16_bus_if
    import tmr16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr,
    input  logic                           rd,
    input  logic [BYTE_W-1:0]              wdata,
    input  logic [CNT_W-1:0]               cnt,
    input  logic [NUM_CH-1:0][CNT_W-1:0]   cmp,
    input  logic [NUM_CH:0]                flags,
    output logic                           cnt_wr,
    output logic [NUM_CH-1:0]              cmp_wr,
    output logic [CNT_W-1:0]               wval,
    output logic [NUM_CH-1:0]              force_p,
    output logic [2*NUM_CH-1:0]            mode_new,
    output logic [2*NUM_CH-1:0]            mode,
    output logic                           ctc,
    output logic [NUM_CH:0]                flag_clr,
    output logic [BYTE_W-1:0]              rdata
);
    localparam int HI_W = CNT_W - BYTE_W;

    reg_addr_e           ra;
    logic [HI_W-1:0]     temp_q;
    logic [2*NUM_CH-1:0] mode_q;
    logic                ctc_q;
    logic                wr_ctrl;
    logic                wr_hi;

    assign ra      = reg_addr_e'(addr);
    assign wr_ctrl = wr && (ra == RA_CTRL);
    assign wr_hi   = wr && (ra == RA_CNT_H || ra == RA_CMPA_H || ra == RA_CMPB_H);

    // Shared high-byte latch: loaded by high-byte writes and low-counter reads
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            temp_q <= '0;
        end else if (wr_hi) begin
            temp_q <= wdata[HI_W-1:0];
        end else if (rd && ra == RA_CNT_L) begin
            temp_q <= cnt[CNT_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            ctc_q  <= 1'b0;
        end else if (wr_ctrl) begin
            mode_q <= wdata[5:2];
            ctc_q  <= wdata[CTC_BIT];
        end
    end

    assign wval      = {temp_q, wdata};
    assign cnt_wr    = wr && (ra == RA_CNT_L);
    assign cmp_wr[0] = wr && (ra == RA_CMPA_L);
    assign cmp_wr[1] = wr && (ra == RA_CMPB_L);
    assign force_p   = {wr_ctrl && wdata[FORCE_B], wr_ctrl && wdata[FORCE_A]};
    assign mode_new  = wdata[5:2];
    assign mode      = mode_q;
    assign ctc       = ctc_q;
    assign flag_clr  = (wr && ra == RA_FLAGS) ? wdata[NUM_CH:0] : '0;

    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (ra)
                RA_CTRL:   rdata = {2'b00, mode_q, 1'b0, ctc_q};
                RA_FLAGS:  rdata = {{(BYTE_W-NUM_CH-1){1'b0}}, flags};
                RA_CNT_L:  rdata = cnt[BYTE_W-1:0];
                RA_CNT_H:  rdata = temp_q;
                RA_CMPA_L: rdata = cmp[0][BYTE_W-1:0];
                RA_CMPA_H: rdata = cmp[0][CNT_W-1:BYTE_W];
                RA_CMPB_L: rdata = cmp[1][BYTE_W-1:0];
                RA_CMPB_H: rdata = cmp[1][CNT_W-1:BYTE_W];
            endcase
        end
    end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wval,
    input  logic             ctc,
    input  logic             eq_a,
    output logic [CNT_W-1:0] cnt,
    output logic             cmp_en,
    output logic             ovf_set,
    output logic             hold_st
);
    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             adv;
    logic             ctc_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_RUN;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CS_RUN:  if (cnt_wr) state_d = CS_HOLD;
            CS_HOLD: if (cnt_wr) state_d = CS_HOLD;
                     else if (tick) state_d = CS_RUN;
        endcase
    end

    // Outputs of the counter control
    always_comb begin
        adv     = tick && !cnt_wr;
        cmp_en  = adv && (state_q == CS_RUN);
        ctc_hit = ctc && eq_a && cmp_en;
        ovf_set = adv && (&cnt_q) && !ctc_hit;
        hold_st = (state_q == CS_HOLD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= wval;
        else if (adv)     cnt_q <= ctc_hit ? '0 : cnt_q + 1'b1;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/tmr16_chan.sv
module tmr16_chan
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wval,
    input  logic             cmp_en,
    input  logic             force_p,
    input  logic [1:0]       mode,
    input  logic [1:0]       mode_new,
    output logic [CNT_W-1:0] cmp_q,
    output logic             eq,
    output logic             match,
    output logic             wave
);
    function automatic logic act(input logic [1:0] m, input logic cur);
        unique case (out_mode_e'(m))
            OM_HOLD:   act = cur;
            OM_TOGGLE: act = !cur;
            OM_CLEAR:  act = 1'b0;
            OM_SET:    act = 1'b1;
        endcase
    endfunction

    assign eq    = (cnt == cmp_q);
    assign match = eq && cmp_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= wval;
    end

    // A strobe uses the mode bits carried in the same control write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       wave <= 1'b0;
        else if (force_p) wave <= act(mode_new, wave);
        else if (match)   wave <= act(mode, wave);
    end
endmodule

// File: rtl/tmr16_cmp_unit.sv
module tmr16_cmp_unit
    import tmr16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tmr_tick,
    input  logic [2:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              wave_a,
    output logic              wave_b,
    output logic              flag_ovf,
    output logic              flag_a,
    output logic              flag_b
);
    logic [CNT_W-1:0]             cnt_q;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_q;
    logic                         cnt_wr;
    logic [NUM_CH-1:0]            cmp_wr;
    logic [CNT_W-1:0]             wval;
    logic [NUM_CH-1:0]            force_p;
    logic [2*NUM_CH-1:0]          mode_new;
    logic [2*NUM_CH-1:0]          mode_q;
    logic                         ctc_q;
    logic [NUM_CH:0]              flag_clr;
    logic [NUM_CH:0]              flags_q;
    logic [NUM_CH:0]              flag_set;
    logic [NUM_CH-1:0]            eq;
    logic [NUM_CH-1:0]            match;
    logic [NUM_CH-1:0]            wave;
    logic                         cmp_en;
    logic                         ovf_set;
    logic                         hold_st;

    tmr16_bus_if #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
        .wdata(bus_wdata), .cnt(cnt_q), .cmp(cmp_q), .flags(flags_q),
        .cnt_wr(cnt_wr), .cmp_wr(cmp_wr), .wval(wval), .force_p(force_p),
        .mode_new(mode_new), .mode(mode_q), .ctc(ctc_q), .flag_clr(flag_clr),
        .rdata(bus_rdata)
    );

    tmr16_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tmr_tick), .cnt_wr(cnt_wr), .wval(wval),
        .ctc(ctc_q), .eq_a(eq[0]), .cnt(cnt_q), .cmp_en(cmp_en),
        .ovf_set(ovf_set), .hold_st(hold_st)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        tmr16_chan #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cmp_wr(cmp_wr[i]), .wval(wval),
            .cmp_en(cmp_en), .force_p(force_p[i]),
            .mode(mode_q[2*NUM_CH-1-2*i -: 2]),
            .mode_new(mode_new[2*NUM_CH-1-2*i -: 2]),
            .cmp_q(cmp_q[i]), .eq(eq[i]), .match(match[i]), .wave(wave[i])
        );
    end

    assign flag_set = {match, ovf_set};

    // Setting wins over a same-cycle clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~flag_clr) | flag_set;
    end

    assign wave_a   = wave[0];
    assign wave_b   = wave[1];
    assign flag_ovf = flags_q[0];
    assign flag_a   = flags_q[1];
    assign flag_b   = flags_q[2];
endmodule

// File: rtl/tmr16_cmp_chk.sv
module tmr16_cmp_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tmr_tick,
    input logic [2:0]       bus_addr,
    input logic             bus_wr,
    input logic             bus_rd,
    input logic [7:0]       bus_rdata,
    input logic             wave_a,
    input logic             flag_ovf,
    input logic             flag_a,
    input logic             flag_b,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] cmp_a,
    input logic             hold_st,
    input logic             ctc,
    input logic [1:0]       mode_a,
    input logic             cnt_wr
);
    assert_wrap_ovf_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && !cnt_wr && (&cnt)) |=> flag_ovf);

    assert_ctc_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && !cnt_wr && !hold_st && ctc && cnt == cmp_a) |=> (cnt == '0));

    assert_match_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_tick && hold_st && !cnt_wr) |=> (!$rose(flag_a) && !$rose(flag_b)));

    assert_force_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0 && !tmr_tick)
        |=> ($stable({flag_ovf, flag_a, flag_b}) && $stable(cnt)));

    assert_strobe_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 3'd0) |-> (bus_rdata[7:6] == 2'b00));

    assert_hold_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!(bus_wr && bus_addr == 3'd0) && mode_a == 2'b00) |=> $stable(wave_a));
endmodule

bind tmr16_cmp_unit tmr16_cmp_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .wave_a(wave_a),
    .flag_ovf(flag_ovf), .flag_a(flag_a), .flag_b(flag_b), .cnt(cnt_q),
    .cmp_a(cmp_q[0]), .hold_st(hold_st), .ctc(ctc_q), .mode_a(mode_q[3:2]),
    .cnt_wr(cnt_wr)
);

// File: tb/tmr16_cmp_unit_tb_top.sv
`timescale 1ns/1ps
module tmr16_cmp_unit_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tmr_tick = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wave_a, wave_b, flag_ovf, flag_a, flag_b;

    typedef struct {
        bit         is_pin;
        logic [7:0] exp;
        string      tag;
    } exp_item_t;

    exp_item_t exp_q[$];
    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 1'b0;

    always #2.5 clk = ~clk;

    tmr16_cmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .tmr_tick(tmr_tick), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .wave_a(wave_a), .wave_b(wave_b),
        .flag_ovf(flag_ovf), .flag_a(flag_a), .flag_b(flag_b)
    );

    // Monitor: compares the oldest expectation away from the rising edge
    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_item_t it;
            logic [7:0] act;
            it  = exp_q.pop_front();
            act = it.is_pin ? {6'b0, wave_a, wave_b} : bus_rdata;
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%02h expected 0x%02h", it.tag, act, it.exp);
            end
        end
    end

    task automatic idle_sigs();
        bus_wr = 1'b0; bus_rd = 1'b0; tmr_tick = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        idle_sigs();
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask

    task automatic wr16(input logic [2:0] lo_a, input logic [15:0] v);
        wr(lo_a + 3'd1, v[15:8]);
        wr(lo_a, v[7:0]);
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        idle_sigs();
        bus_rd = 1'b1; bus_addr = a;
        it.is_pin = 1'b0; it.exp = e; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic pin_chk(input logic [1:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        idle_sigs();
        it.is_pin = 1'b1; it.exp = {6'b0, e}; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            idle_sigs();
            tmr_tick = 1'b1;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(3'd0, 8'h00, "R1 ctrl");
        rd_chk(3'd1, 8'h00, "R1 flags");
        rd_chk(3'd2, 8'h00, "R1 cnt lo");
        rd_chk(3'd4, 8'h00, "R1 cmpA lo");
        pin_chk(2'b00, "R1 pins");

        // R2 latched writes and shared latch
        wr(3'd5, 8'h12);
        rd_chk(3'd5, 8'h00, "R2 high alone no effect");
        wr(3'd4, 8'h34);
        rd_chk(3'd5, 8'h12, "R2 cmpA hi");
        rd_chk(3'd4, 8'h34, "R2 cmpA lo");
        wr(3'd3, 8'hAB);
        wr(3'd6, 8'h05);
        rd_chk(3'd7, 8'hAB, "R2 shared latch");
        rd_chk(3'd2, 8'h00, "R2 counter untouched lo");
        rd_chk(3'd3, 8'h00, "R2 counter untouched hi");

        // R4 wrap and overflow (first tick after write is blocked, still advances)
        wr16(3'd2, 16'hFFFD);
        ticks(4);
        rd_chk(3'd1, 8'h01, "R4 overflow flag");
        rd_chk(3'd2, 8'h01, "R4 count lo after wrap");
        rd_chk(3'd3, 8'h00, "R4 count hi after wrap");
        wr(3'd1, 8'h01);
        rd_chk(3'd1, 8'h00, "R11 overflow cleared");

        // R3 read latch keeps the high byte
        wr16(3'd2, 16'h02FE);
        rd_chk(3'd2, 8'hFE, "R3 lo");
        ticks(3);
        rd_chk(3'd3, 8'h02, "R3 latched hi");
        rd_chk(3'd2, 8'h01, "R3 lo moved");
        rd_chk(3'd3, 8'h03, "R3 new hi");

        // R5/R6 matches: A toggle, B set
        wr(3'd0, 8'h1C);
        wr16(3'd4, 16'h0310);
        wr16(3'd6, 16'h0312);
        ticks(16);
        pin_chk(2'b10, "R6 toggle A");
        rd_chk(3'd1, 8'h02, "R5 flag A");
        ticks(2);
        pin_chk(2'b11, "R6 set B");
        rd_chk(3'd1, 8'h06, "R5 flag B");
        wr(3'd1, 8'h02);
        rd_chk(3'd1, 8'h04, "R11 partial clear");
        wr(3'd1, 8'h04);
        rd_chk(3'd1, 8'h00, "R11 full clear");

        // R6 clear action
        wr(3'd0, 8'h2C);
        wr16(3'd2, 16'h030F);
        ticks(2);
        pin_chk(2'b01, "R6 clear A");
        wr(3'd1, 8'h07);

        // R6 hold action
        wr(3'd0, 8'h0C);
        wr16(3'd2, 16'h030F);
        ticks(2);
        pin_chk(2'b01, "R6 hold A");
        rd_chk(3'd1, 8'h02, "R5 flag A under hold");
        wr(3'd1, 8'h07);

        // R8 blocking after counter write
        wr(3'd0, 8'h1C);
        wr16(3'd2, 16'h0310);
        ticks(1);
        pin_chk(2'b01, "R8 no toggle A");
        rd_chk(3'd1, 8'h00, "R8 no flag A");
        wr16(3'd2, 16'h0312);
        ticks(1);
        rd_chk(3'd1, 8'h00, "R8 no flag B");

        // R7 clear-on-compare
        wr(3'd0, 8'h1D);
        rd_chk(3'd0, 8'h1D, "R10 ctrl readback");
        wr16(3'd2, 16'h030E);
        ticks(3);
        rd_chk(3'd2, 8'h00, "R7 reload lo");
        rd_chk(3'd3, 8'h00, "R7 reload hi");
        pin_chk(2'b11, "R7 toggle A on reload");
        rd_chk(3'd1, 8'h02, "R7 no overflow");

        // R9/R10 forced actions
        wr(3'd1, 8'h07);
        wr(3'd0, 8'hAD);
        pin_chk(2'b01, "R9 force A clear");
        rd_chk(3'd1, 8'h00, "R9 force no flag");
        rd_chk(3'd0, 8'h2D, "R10 strobe reads zero");
        wr(3'd0, 8'h69);
        pin_chk(2'b00, "R9 force B clear");
        wr16(3'd2, 16'h0310);
        wr(3'd0, 8'h99);
        pin_chk(2'b10, "R9 force A toggle");
        rd_chk(3'd2, 8'h10, "R9 counter kept lo");
        rd_chk(3'd3, 8'h03, "R9 counter kept hi");
        rd_chk(3'd1, 8'h00, "R9 no flag in clear-on-compare");

        @(negedge clk);
        idle_sigs();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule